// File: doc/BRIEF.md
# Page-Mode Asynchronous SRAM Controller

This block sits between an internal request port and an external asynchronous low-power SRAM of 256K words by 16 bits. It turns single-word writes with per-byte masks, single reads and read bursts of up to 16 words into the chip-select, write-strobe, output-enable and byte-lane pin sequences the memory needs. Every phase is timed by a countdown loaded with a clock-cycle count that is set through a parameter, so one netlist can serve different system clocks and speed grades.

The memory keeps an internal page of 16 words open as long as the page bits of the address do not move. The word inside the page is chosen by address bits 4:1, and bit 0 belongs to the page. A read burst walks through the words of the open page. Every word after the first waits only for the short page access time. When a burst runs off the end of a page, it carries on into the next page after a full random-access wait. When the controller has nothing to do, it deselects the memory so the memory drops into standby.

Top module: `pgsram_ctrl`

## Requirements
- R1: While reset is asserted: CE1 is high, CE2 is low, WE and OE are high, both byte lanes are high, the data bus is not driven and no read-valid strobe is given.
- R2: An accepted single read returns the word at the requested address with exactly one rd_valid_o pulse, T_RAND clock edges after the accepting edge.
- R3: Burst words come in logical order. The logical address is {addr[17:5], addr[0], addr[4:1]}, and each further word is the logical address plus one, so addr[4:1] counts up first, then addr[0], then addr[17:5]. It wraps from the top address to zero.
- R4: Inside one page, each burst word after the first arrives T_PAGE edges after the one before it, and the page bits (addr[17:5] and addr[0]) stay fixed while the word index changes.
- R5: When a burst crosses from word index 15 into the next page, the first word of the new page arrives T_RAND edges after the previous word.
- R6: A write changes bits 7:0 only when req_be_i[0] is 1 (LB low) and bits 15:8 only when req_be_i[1] is 1 (UB low). A lane whose enable is clear keeps its old contents.
- R7: A write gives one setup cycle with WE high, then WE low for exactly T_WP cycles, then one hold cycle with WE high. Address and data stay steady throughout, and OE stays high.
- R8: The controller drives the data bus only during the three write phases and never while OE is low.
- R9: After the last word of a read, the memory stays deselected and the bus undriven for T_TURN cycles before req_ready_o returns.
- R10: req_ready_o is high only when the controller is idle, and the memory is deselected whenever it is idle. req_len_i holds the burst length minus one (0 to 15). Writes are always a single word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle and accepting |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Word address of the first word |
| req_len_i | input | 4 | Read burst length minus one |
| req_be_i | input | 2 | Write byte enables, bit 0 for the low byte |
| req_wdata_i | input | 16 | Write data |
| rd_valid_o | output | 1 | One pulse per returned word |
| rd_data_o | output | 16 | Returned word |
| mem_addr_o | output | 18 | Memory address bus |
| mem_ce1_no | output | 1 | Chip enable, active low |
| mem_ce2_o | output | 1 | Chip enable, active high |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_ub_no | output | 1 | Upper byte lane enable, active low |
| mem_lb_no | output | 1 | Lower byte lane enable, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data read from the memory |

## Verification
The responder returns a garbage word until the address has been held for the access time that applies: the page time when only the word index moved within an open page, and the random time otherwise. It also tracks the real wait between consecutive words. A design that used the page time across a page boundary, or counted one cycle short, therefore returns wrong data and wrong spacing. A burst that starts at word index 14 with address bit 0 clear must land on address 1 after two words. A controller that incremented the plain address, or kept bit 0 as the word's low bit, reads the wrong locations. Writes with one lane masked show whether the masked byte survives. The count of WE-low cycles and the count of idle cycles after each read expose an off-by-one in the write pulse or in the bus turnaround.

// File: rtl/pgsram_pkg.sv
package pgsram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WSET,
    ST_WPUL,
    ST_WHLD
  } pg_state_e;
endpackage

// File: rtl/pgsram_timer.sv
module pgsram_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  // load N -> done in the Nth cycle after the load edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i - CNT_W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);

  assert_load_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (val_i != '0));
endmodule

// File: rtl/pgsram_burst_seq.sv
module pgsram_burst_seq #(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned PAGE_BITS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 step_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [PAGE_BITS-1:0] len_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 last_o,
  output logic                 wrap_o
);
  localparam int unsigned HI_LSB = PAGE_BITS + 1;

  // logical order: {upper page bits, bit 0, word index}
  logic [ADDR_W-1:0]    log_q;
  logic [PAGE_BITS-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      log_q <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      log_q <= {addr_i[ADDR_W-1:HI_LSB], addr_i[0], addr_i[PAGE_BITS:1]};
      rem_q <= len_i;
    end else if (step_i) begin
      log_q <= log_q + ADDR_W'(1);
      rem_q <= rem_q - PAGE_BITS'(1);
    end
  end

  assign addr_o = {log_q[ADDR_W-1:HI_LSB], log_q[PAGE_BITS-1:0], log_q[PAGE_BITS]};
  assign last_o = (rem_q == '0);
  assign wrap_o = &log_q[PAGE_BITS-1:0];

  assert_page_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wrap_o) |=>
      ({addr_o[ADDR_W-1:HI_LSB], addr_o[0]} == $past({addr_o[ADDR_W-1:HI_LSB], addr_o[0]})));

  assert_step_not_last_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !last_o);
endmodule

// File: rtl/pgsram_ctrl.sv
module pgsram_ctrl
  import pgsram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PAGE_BITS = 4,
  parameter int unsigned T_RAND    = 6,
  parameter int unsigned T_PAGE    = 3,
  parameter int unsigned T_WP      = 4,
  parameter int unsigned T_TURN    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [PAGE_BITS-1:0] req_len_i,
  input  logic [1:0]           req_be_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  output logic                 rd_valid_o,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic                 mem_ce1_no,
  output logic                 mem_ce2_o,
  output logic                 mem_we_no,
  output logic                 mem_oe_no,
  output logic                 mem_ub_no,
  output logic                 mem_lb_no,
  output logic [DATA_W-1:0]    mem_dq_o,
  output logic                 mem_dq_oe_o,
  input  logic [DATA_W-1:0]    mem_dq_i
);
  localparam int unsigned T_A   = (T_RAND > T_PAGE) ? T_RAND : T_PAGE;
  localparam int unsigned T_B   = (T_WP > T_TURN) ? T_WP : T_TURN;
  localparam int unsigned T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int unsigned CNT_W = $clog2(T_MAX + 1);

  pg_state_e state_q, state_d;

  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             seq_load, seq_step, seq_last, seq_wrap;
  logic             cap;
  logic [1:0]       be_q;
  logic [DATA_W-1:0] wdata_q;
  logic             rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  pgsram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  pgsram_burst_seq #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (seq_load),
    .step_i (seq_step),
    .addr_i (req_addr_i),
    .len_i  (req_len_i),
    .addr_o (mem_addr_o),
    .last_o (seq_last),
    .wrap_o (seq_wrap)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    seq_load = 1'b0;
    seq_step = 1'b0;
    cap      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        seq_load = 1'b1;
        if (req_write_i) begin
          state_d = ST_WSET;
        end else begin
          state_d  = ST_RD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_RAND);
        end
      end
      ST_RD: if (tmr_done) begin
        cap      = 1'b1;
        tmr_load = 1'b1;
        if (seq_last) begin
          state_d = ST_TURN;
          tmr_val = CNT_W'(T_TURN);
        end else begin
          seq_step = 1'b1;
          // crossing the page boundary reopens a page: full access wait
          tmr_val  = seq_wrap ? CNT_W'(T_RAND) : CNT_W'(T_PAGE);
        end
      end
      ST_TURN: if (tmr_done) state_d = ST_IDLE;
      ST_WSET: begin
        state_d  = ST_WPUL;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_WP);
      end
      ST_WPUL: if (tmr_done) state_d = ST_WHLD;
      ST_WHLD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      be_q       <= '0;
      wdata_q    <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      state_q    <= state_d;
      rd_valid_q <= cap;
      if (cap) rd_data_q <= mem_dq_i;
      if (state_q == ST_IDLE && req_valid_i && req_write_i) begin
        be_q    <= req_be_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  logic sel, rd_ph, wr_ph;
  assign rd_ph = (state_q == ST_RD);
  assign wr_ph = (state_q == ST_WSET) || (state_q == ST_WPUL) || (state_q == ST_WHLD);
  assign sel   = rd_ph || wr_ph;

  assign req_ready_o = (state_q == ST_IDLE);
  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign mem_ce1_no  = !sel;
  assign mem_ce2_o   = sel;
  assign mem_oe_no   = !rd_ph;
  assign mem_we_no   = !(state_q == ST_WPUL);
  assign mem_lb_no   = !(rd_ph || (wr_ph && be_q[0]));
  assign mem_ub_no   = !(rd_ph || (wr_ph && be_q[1]));
  assign mem_dq_oe_o = wr_ph;
  assign mem_dq_o    = wdata_q;

  assert_idle_deselect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce1_no && !mem_ce2_o && !mem_dq_oe_o));

  assert_drive_no_oe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  assert_we_selected_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce1_no && mem_ce2_o && mem_dq_oe_o && mem_oe_no));

  assert_we_addr_steady_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && $past(!mem_we_no)) |-> $stable(mem_addr_o));

  assert_turn_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_no) |-> (mem_ce1_no && !mem_dq_oe_o));

  assert_rdv_after_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(!mem_oe_no));
endmodule

// File: tb/pgsram_ctrl_bench.sv
module pgsram_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_RAND = 6;
  localparam int T_PAGE = 3;
  localparam int T_WP   = 4;
  localparam int T_TURN = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid, req_ready, req_write;
  logic [17:0] req_addr;
  logic [3:0]  req_len;
  logic [1:0]  req_be;
  logic [15:0] req_wdata;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [17:0] mem_addr;
  logic        ce1_n, ce2, we_n, oe_n, ub_n, lb_n, dq_oe;
  logic [15:0] dq_o;
  logic [15:0] dq_i;

  pgsram_ctrl #(
    .T_RAND(T_RAND), .T_PAGE(T_PAGE), .T_WP(T_WP), .T_TURN(T_TURN)
  ) u_pgsram_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .mem_addr_o(mem_addr), .mem_ce1_no(ce1_n), .mem_ce2_o(ce2), .mem_we_no(we_n),
    .mem_oe_no(oe_n), .mem_ub_no(ub_n), .mem_lb_no(lb_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  int  checks = 0, errors = 0, cyc = 0, viol = 0;
  bit  done = 0;
  logic [15:0] rsp_mem [int];
  logic [15:0] exp_mem [int];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] dflt(logic [17:0] a);
    return a[15:0] ^ 16'h5A5A;
  endfunction
  function automatic logic [15:0] rsp_rd(logic [17:0] a);
    if (rsp_mem.exists(int'(a))) return rsp_mem[int'(a)];
    return dflt(a);
  endfunction
  function automatic logic [15:0] exp_rd(logic [17:0] a);
    if (exp_mem.exists(int'(a))) return exp_mem[int'(a)];
    return dflt(a);
  endfunction
  // R3: logical order {a[17:5], a[0], a[4:1]} plus one
  function automatic logic [17:0] next_phys(logic [17:0] a);
    logic [17:0] l;
    l = {a[17:5], a[0], a[4:1]} + 18'd1;
    return {l[17:5], l[3:0], l[4]};
  endfunction
  function automatic bit same_page(logic [17:0] a, logic [17:0] b);
    return {a[17:5], a[0]} == {b[17:5], b[0]};
  endfunction

  // responder: data only after the applicable access time
  logic [17:0] r_prev_addr = '0;
  bit          r_prev_rd = 0, r_prev_wl = 0;
  int          r_hold = 0, r_need = T_RAND;
  logic [15:0] r_word;
  initial dq_i = 16'hBAD0;
  always @(negedge clk) begin
    bit sel, rd_en;
    sel   = !ce1_n && ce2;
    rd_en = sel && !oe_n && we_n;
    if (!rd_en) r_hold = 0;
    else if (r_prev_rd && mem_addr == r_prev_addr) r_hold++;
    else begin
      r_need = (r_prev_rd && same_page(mem_addr, r_prev_addr)) ? T_PAGE : T_RAND;
      r_hold = 1;
    end
    dq_i = (rd_en && r_hold >= r_need) ? rsp_rd(mem_addr) : 16'hBAD0;
    if (sel && we_n && r_prev_wl && dq_oe) begin
      r_word = rsp_rd(mem_addr);
      if (!lb_n) r_word[7:0]  = dq_o[7:0];
      if (!ub_n) r_word[15:8] = dq_o[15:8];
      rsp_mem[int'(mem_addr)] = r_word;
    end
    if (rst_n) begin
      if (dq_oe && !oe_n) viol++;
      if (!we_n && r_prev_wl && mem_addr != r_prev_addr) viol++;
      if (!we_n && !sel) viol++;
    end
    r_prev_wl   = sel && !we_n;
    r_prev_rd   = rd_en;
    r_prev_addr = mem_addr;
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [17:0] a, input logic [1:0] be, input logic [15:0] d);
    int n_low, oe_bad;
    logic [15:0] w;
    @(negedge clk);
    req_write = 1'b1; req_addr = a; req_len = 4'd0; req_be = be; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    w = exp_rd(a);
    if (be[0]) w[7:0]  = d[7:0];
    if (be[1]) w[15:8] = d[15:8];
    exp_mem[int'(a)] = w;
    n_low = 0; oe_bad = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) begin
      if (!we_n) n_low++;
      if (!oe_n) oe_bad++;
      @(negedge clk);
    end
    chk(n_low == T_WP, "R7", "we low cycles", n_low, T_WP);
    chk(oe_bad == 0, "R7", "oe low during write", oe_bad, 0);
    chk(ce1_n && !ce2 && !dq_oe, "R10", "idle deselect after write", {ce1_n, ce2, dq_oe}, 3'b100);
  endtask

  task automatic do_read(input logic [17:0] a0, input logic [3:0] len);
    int acc, prev_t, gap, exp_gap, busy_bad, n, bad;
    logic [17:0] a, prev_a;
    @(negedge clk);
    req_write = 1'b0; req_addr = a0; req_len = len; req_be = 2'b00; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    @(posedge clk);
    a = a0; prev_a = a0; prev_t = acc; busy_bad = 0;
    for (int w = 0; w <= int'(len); w++) begin
      do begin
        @(negedge clk);
        req_valid = 1'b0;
        if (!rd_valid && req_ready) busy_bad++;
      end while (!rd_valid);
      gap = cyc - prev_t;
      if (w == 0) begin
        chk(gap == T_RAND, "R2", "first word latency", gap, T_RAND);
        chk(rd_data == exp_rd(a), "R2", "first word data", rd_data, exp_rd(a));
      end else if (same_page(a, prev_a)) begin
        chk(gap == T_PAGE, "R4", "page word spacing", gap, T_PAGE);
        chk(rd_data == exp_rd(a), "R3", "burst word data", rd_data, exp_rd(a));
      end else begin
        chk(gap == T_RAND, "R5", "page crossing spacing", gap, T_RAND);
        chk(rd_data == exp_rd(a), "R5", "new page word data", rd_data, exp_rd(a));
      end
      prev_t = cyc; prev_a = a; a = next_phys(a);
    end
    chk(busy_bad == 0, "R10", "ready while busy", busy_bad, 0);
    n = 0; bad = 0;
    do begin
      @(negedge clk);
      n++;
      if (!ce1_n || dq_oe) bad++;
    end while (!req_ready);
    chk(n == T_TURN, "R9", "turnaround cycles", n, T_TURN);
    chk(bad == 0, "R9", "selected during turnaround", bad, 0);
  endtask

  // {write, addr[17:0], len[3:0], be[1:0], data[15:0]}
  localparam int NV = 13;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 18'h00010, 4'd0,  2'b11, 16'h1234},
    {1'b0, 18'h00010, 4'd0,  2'b00, 16'h0000},
    {1'b1, 18'h00010, 4'd0,  2'b01, 16'h99AB},  // R6 low lane only
    {1'b0, 18'h00010, 4'd0,  2'b00, 16'h0000},
    {1'b1, 18'h00010, 4'd0,  2'b10, 16'hCD77},  // R6 high lane only
    {1'b0, 18'h00010, 4'd0,  2'b00, 16'h0000},
    {1'b1, 18'h00001, 4'd0,  2'b11, 16'h7777},  // bit 0 is a page bit
    {1'b0, 18'h00000, 4'd1,  2'b00, 16'h0000},
    {1'b0, 18'h00001, 4'd0,  2'b00, 16'h0000},
    {1'b0, 18'h0001C, 4'd3,  2'b00, 16'h0000},  // R5 crossing lands on 0x00001
    {1'b0, 18'h00000, 4'd15, 2'b00, 16'h0000},  // R4 full page
    {1'b1, 18'h3FFFF, 4'd0,  2'b11, 16'hBEEF},
    {1'b0, 18'h3FFFF, 4'd1,  2'b00, 16'h0000}   // R3 wrap to zero
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0; req_be = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(ce1_n && !ce2, "R1", "reset chip select", {ce1_n, ce2}, 2'b10);
    chk(we_n && oe_n && ub_n && lb_n, "R1", "reset strobes", {we_n, oe_n, ub_n, lb_n}, 4'hF);
    chk(!dq_oe && !rd_valid, "R1", "reset bus and valid", {dq_oe, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && ce1_n, "R10", "idle after reset", {req_ready, ce1_n}, 2'b11);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) do_write(VEC[i][39:22], VEC[i][17:16], VEC[i][15:0]);
      else            do_read(VEC[i][39:22], VEC[i][21:18]);
    end

    // corner: read immediately after a masked write to an unwritten word
    do_write(18'h20A5A, 2'b10, 16'h3C00);
    do_read(18'h20A5A, 4'd0);
    // corner: burst starting at word 15 with bit 0 set crosses into the upper page bits
    do_read(18'h0003F, 4'd2);

    chk(viol == 0, "R8", "responder protocol violations", viol, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule